// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 32-bit down-counter for one processor's local interrupt unit. It does not decrement once per clock. Instead, an upstream time-keeping agent presents batches of elapsed core ticks, one batch per update strobe. Each batch is shifted right by a power-of-two divide setting, and the result is taken off the live count in one step. When a batch uses up the remaining count, the timer expires. It then emits a one-cycle raise pulse that carries the 8-bit vector held in its vector entry, unless the entry's mask bit is set.

Software sees four 32-bit registers through a simple write/read port with a byte address. These are the vector entry, the initial count, the current count and the divide setting. Writing the initial count arms the counter, because it loads the live count as well. A zero initial count leaves the timer inert.

There are two modes. In one-shot mode the count parks at zero after expiry. In periodic mode the count reloads, and ticks that overshot zero are carried into the next period, so the reload is shortened by the overshoot modulo the initial count.

Top module: `local_timer`

## Requirements
- R1: After reset the vector entry (byte address 0x320) reads 0x00010000, and the initial count (0x380), current count (0x390) and divide setting (0x3E0) read 0. A read strobe returns data on `reg_rdata` in the cycle after the strobe.
- R2: A write to 0x380 sets both the initial count and the current count to the written value.
- R3: A write to 0x390 sets only the current count. A read of 0x390 returns the live count.
- R4: The divide code is formed from bits {3,1,0} of the divide setting. Codes 000..110 divide by 2,4,8,16,32,64,128, and 111 divides by 1. Bit 2 has no effect. Prescaled ticks are `tick_count` shifted right by the selected amount, and the remainder is discarded.
- R5: While the initial count is zero, updates change neither the current count nor `timer_fire`, even if the current count is nonzero.
- R6: When an update's prescaled ticks are fewer than the current count, the current count drops by exactly that amount and nothing is raised.
- R7: When prescaled ticks are greater than or equal to the current count on an active timer, `timer_fire` is high for one cycle in the cycle after the update. `timer_vector` carries bits [7:0] of the vector entry.
- R8: With entry bit 17 set (periodic), expiry reloads the current count with initial − ((ticks − current) mod initial).
- R9: With entry bit 17 clear (one-shot), the count stays at zero after expiry, and later updates raise nothing.
- R10: With entry bit 16 set (masked), expiry raises nothing, but the count still decrements, expires and reloads as in R6–R9.
- R11: A register write in the same cycle as an update takes precedence, and that update is dropped. Writes to unmapped addresses change nothing, and reads of them return 0.
- R12: In periodic mode with a nonzero initial count and a current count of zero, any update expires at once, including one with zero ticks, and reloads the initial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tick_valid | input | 1 | Update strobe for a batch of elapsed core ticks |
| tick_count | input | 16 | Core ticks elapsed in this update |
| timer_fire | output | 1 | One-cycle raise pulse on unmasked expiry |
| timer_vector | output | 8 | Vector carried with the raise pulse |

## Verification
The hardest cases to reach are in periodic reload. Here the overshoot must exceed a whole period, so that the modulo term is neither zero nor the raw excess. A related case is a periodic counter that sits at zero and must expire on an update that carries no ticks.

The stimulus reaches the first case by selecting the divide-by-one code and issuing a single large batch against a small initial count. It reaches the second by writing the current count to zero directly, after arming the initial count. Both results are read back through the register port.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int CNT_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int TICK_W  = 16;
  localparam int VEC_W   = 8;

  localparam logic [ADDR_W-1:0] A_ENTRY = 12'h320;
  localparam logic [ADDR_W-1:0] A_INIT  = 12'h380;
  localparam logic [ADDR_W-1:0] A_CUR   = 12'h390;
  localparam logic [ADDR_W-1:0] A_DIV   = 12'h3E0;

  localparam logic [CNT_W-1:0] ENTRY_RST = 32'h0001_0000;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef enum logic {ONE_SHOT = 1'b0, PERIODIC = 1'b1} tmode_e;

  // Map the 3-bit divide code to a right-shift amount (111 -> none).
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'b111) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale #(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic [3:0]        div_cfg,
  input  logic [TICK_W-1:0] ticks,
  output logic [CNT_W-1:0]  pticks
);
  import ltmr_pkg::*;
  localparam int NSH = 8;

  logic [2:0] code;
  logic [2:0] sh;
  logic [TICK_W-1:0] shifted [NSH];

  assign code = {div_cfg[3], div_cfg[1], div_cfg[0]};
  assign sh   = div_shift(code);

  // One candidate per shift amount; the decoded code selects one.
  for (genvar g = 0; g < NSH; g++) begin : g_sh
    assign shifted[g] = ticks >> g;
  end

  assign pticks = CNT_W'(shifted[sh]);
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             upd,
  input  logic [CNT_W-1:0] pticks,
  input  logic [CNT_W-1:0] init,
  input  logic             periodic,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec,
  output logic [CNT_W-1:0] cur,
  output logic             fire,
  output logic [VEC_W-1:0] fire_vec
);
  logic             active;
  logic             expire;
  logic [CNT_W-1:0] excess;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] reload;

  assign active = (init != '0) && (periodic || (cur != '0));
  assign expire = upd && !load_en && active && (pticks >= cur);
  assign excess = pticks - cur;
  assign rem    = (init == '0) ? '0 : (excess % init);
  assign reload = init - rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      fire     <= 1'b0;
      fire_vec <= '0;
    end else begin
      fire <= expire && !masked;
      if (expire) fire_vec <= vec;
      if (load_en)
        cur <= load_val;
      else if (upd && active) begin
        if (pticks < cur) cur <= cur - pticks;
        else              cur <= periodic ? reload : '0;
      end
    end
  end

  assert_oneshot_park_R9: assert property (@(posedge clk) disable iff (rst)
    (!periodic && cur == '0 && !load_en) |=> (cur == '0 && !fire));

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    masked |=> !fire);

  assert_reload_range_R8: assert property (@(posedge clk) disable iff (rst)
    (upd && !load_en && periodic && init != '0 && pticks >= cur)
      |=> (cur != '0 && cur <= $past(init)));

  assert_decrement_R6: assert property (@(posedge clk) disable iff (rst)
    (upd && !load_en && init != '0 && pticks < cur)
      |=> (cur == $past(cur) - $past(pticks) && !fire));

  assert_inert_R5: assert property (@(posedge clk) disable iff (rst)
    (init == '0 && !load_en) |=> ($stable(cur) && !fire));
endmodule

// File: rtl/local_timer.sv
module local_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int TICK_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_valid,
  input  logic [TICK_W-1:0] tick_count,
  output logic              timer_fire,
  output logic [VEC_W-1:0]  timer_vector
);
  import ltmr_pkg::*;

  logic [DATA_W-1:0] entry_q;
  logic [DATA_W-1:0] init_q;
  logic [3:0]        div_q;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] pticks;
  logic              wr_entry, wr_init, wr_cur, wr_div, any_wr;
  logic              load_en;

  assign wr_entry = reg_wr && (reg_addr == ADDR_W'(A_ENTRY));
  assign wr_init  = reg_wr && (reg_addr == ADDR_W'(A_INIT));
  assign wr_cur   = reg_wr && (reg_addr == ADDR_W'(A_CUR));
  assign wr_div   = reg_wr && (reg_addr == ADDR_W'(A_DIV));
  assign any_wr   = wr_entry | wr_init | wr_cur | wr_div;
  assign load_en  = wr_init | wr_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= DATA_W'(ENTRY_RST);
      init_q  <= '0;
      div_q   <= '0;
    end else begin
      if (wr_entry) entry_q <= reg_wdata;
      if (wr_init)  init_q  <= reg_wdata;
      if (wr_div)   div_q   <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(A_ENTRY): reg_rdata <= entry_q;
        ADDR_W'(A_INIT):  reg_rdata <= init_q;
        ADDR_W'(A_CUR):   reg_rdata <= cur;
        ADDR_W'(A_DIV):   reg_rdata <= DATA_W'(div_q);
        default:          reg_rdata <= '0;
      endcase
    end
  end

  ltmr_prescale #(.TICK_W(TICK_W), .CNT_W(DATA_W)) u_pre (
    .div_cfg (div_q),
    .ticks   (tick_count),
    .pticks  (pticks)
  );

  ltmr_counter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (reg_wdata),
    .upd      (tick_valid && !any_wr),
    .pticks   (pticks),
    .init     (init_q),
    .periodic (entry_q[MODE_BIT]),
    .masked   (entry_q[MASK_BIT]),
    .vec      (entry_q[VEC_W-1:0]),
    .cur      (cur),
    .fire     (timer_fire),
    .fire_vec (timer_vector)
  );

  assert_init_arms_R2: assert property (@(posedge clk) disable iff (rst)
    wr_init |=> (cur == $past(reg_wdata) && init_q == $past(reg_wdata)));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (any_wr && tick_valid) |=> !timer_fire);

  assert_fire_cause_R7: assert property (@(posedge clk) disable iff (rst)
    timer_fire |-> $past(tick_valid));
endmodule

// File: tb/local_timer_tb_top.sv
module local_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd, tick_valid;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] tick_count;
  logic        timer_fire;
  logic [7:0]  timer_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic last_fire;
  logic [7:0] last_vec;

  always #2 clk = ~clk;

  local_timer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_valid(tick_valid), .tick_count(tick_count),
    .timer_fire(timer_fire), .timer_vector(timer_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick(input logic [15:0] n);
    @(negedge clk);
    tick_valid = 1'b1; tick_count = n;
    @(negedge clk);
    tick_valid = 1'b0;
    last_fire = timer_fire;
    last_vec  = timer_vector;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h320, v); check("R1 entry", v, 32'h0001_0000);
    rd(12'h380, v); check("R1 init", v, 0);
    rd(12'h390, v); check("R1 cur", v, 0);
    rd(12'h3E0, v); check("R1 div", v, 0);
    check("R1 fire", 32'(timer_fire), 0);
  endtask

  task automatic t_inert();
    logic [31:0] v;
    wr(12'h320, 32'h21);
    wr(12'h390, 50);
    tick(10);
    check("R5 fire", 32'(last_fire), 0);
    rd(12'h390, v); check("R5 cur", v, 50);
  endtask

  task automatic t_load_dec();
    logic [31:0] v;
    wr(12'h3E0, 32'hB);
    wr(12'h380, 100);
    rd(12'h390, v); check("R2 cur", v, 100);
    rd(12'h380, v); check("R2 init", v, 100);
    tick(30);
    check("R6 fire", 32'(last_fire), 0);
    rd(12'h390, v); check("R6 cur", v, 70);
    wr(12'h390, 44);
    rd(12'h390, v); check("R3 cur", v, 44);
    rd(12'h380, v); check("R3 init", v, 100);
  endtask

  task automatic t_div();
    logic [31:0] v;
    wr(12'h3E0, 32'h8);
    wr(12'h380, 1000);
    tick(100);
    rd(12'h390, v); check("R4 div32", v, 997);
    wr(12'h3E0, 32'h4);
    wr(12'h380, 1000);
    tick(11);
    rd(12'h390, v); check("R4 bit2 ignored div2", v, 995);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(12'h3E0, 32'hB);
    wr(12'h320, 32'h33);
    wr(12'h380, 6);
    tick(6);
    check("R7 fire", 32'(last_fire), 1);
    check("R7 vector", 32'(last_vec), 32'h33);
    @(negedge clk);
    check("R7 one cycle", 32'(timer_fire), 0);
    rd(12'h390, v); check("R9 parked", v, 0);
    tick(100);
    check("R9 no refire", 32'(last_fire), 0);
    rd(12'h390, v); check("R9 still zero", v, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(12'h320, 32'h0002_0040);
    wr(12'h380, 10);
    tick(25);
    check("R8 fire", 32'(last_fire), 1);
    check("R8 vector", 32'(last_vec), 32'h40);
    rd(12'h390, v); check("R8 carry reload", v, 5);
    tick(5);
    check("R8 exact fire", 32'(last_fire), 1);
    rd(12'h390, v); check("R8 full reload", v, 10);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(12'h320, 32'h0001_0055);
    wr(12'h380, 20);
    tick(7);
    rd(12'h390, v); check("R10 counts", v, 13);
    tick(30);
    check("R10 no raise", 32'(last_fire), 0);
    rd(12'h390, v); check("R10 expired", v, 0);
  endtask

  task automatic t_zero_periodic();
    logic [31:0] v;
    wr(12'h320, 32'h0002_0077);
    wr(12'h380, 8);
    wr(12'h390, 0);
    tick(0);
    check("R12 fire", 32'(last_fire), 1);
    check("R12 vector", 32'(last_vec), 32'h77);
    rd(12'h390, v); check("R12 reload", v, 8);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(12'h320, 32'h21);
    wr(12'h380, 60);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h390; reg_wdata = 40;
    tick_valid = 1'b1; tick_count = 100;
    @(negedge clk);
    reg_wr = 1'b0; tick_valid = 1'b0;
    check("R11 no fire", 32'(timer_fire), 0);
    rd(12'h390, v); check("R11 write wins", v, 40);
    wr(12'h3F0, 32'hDEAD);
    rd(12'h3F0, v); check("R11 unmapped", v, 0);
    rd(12'h390, v); check("R11 unmapped no effect", v, 40);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tick_valid = 0; tick_count = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_inert();
    t_load_dec();
    t_div();
    t_oneshot();
    t_periodic();
    t_masked();
    t_zero_periodic();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule